// File: doc/BRIEF.md
# SPI Frame CRC Unit

This unit sits beside an SPI shift engine and protects a frame sequence with a CRC. It keeps two running checksums, one over the words shifted out and one over the words shifted in. Both use a generator polynomial supplied by software, which must be odd. The checksum can be 8 or 16 bits wide, and the frames can be 8 or 16 bits wide. Each accumulator folds in one whole frame, MSB first, in the clock cycle where the shifter reports the frame complete.

Software enables the CRC and streams its data. Before the final data frame finishes, software raises a one-cycle request. When that frame completes, the unit enters a CRC phase and clears the request. In the CRC phase it steers the TX checksum onto the shifter's transmit word and freezes both accumulators. A 16-bit checksum on 8-bit frames goes out as two frames, high byte first. All other combinations use one frame. Received CRC frames still reach the receive path as ordinary data. After the last CRC frame, the unit compares the received value with the RX accumulator. On a mismatch it sets a sticky error flag, which only a software clear removes. To restart the checksums, software drops the enable and raises it again.

Top module: `spi_crc_unit`

## Requirements
- R1: After reset, both accumulators are 0 and the CRC phase, CRC-next and error outputs are all 0.
- R2: In the cycle where `crc_en_i` rises, both accumulators are cleared to 0. This clear takes priority over a frame update in the same cycle.
- R3: A frame completes when `frame_done_i` is high, `crc_en_i` is high and the unit is outside the CRC phase. On that clock edge, `tx_data_i` is folded into the TX accumulator and `rx_data_i` into the RX accumulator.
  - The fold is MSB first, using `poly_i` and the whole frame width.
  - The frame width is 16 bits when `frame16_i`=1 and the low 8 bits otherwise.
  - The CRC width is 16 bits when `crc16_i`=1 and 8 bits otherwise; an 8-bit CRC reads as zero in bits 15:8.
- R4: `crc_next_set_i` sets `crc_next_o`. When a frame completes while `crc_next_o` is 1, that frame is still folded in. From the next cycle, `crc_phase_o` is 1 and `crc_next_o` is 0.
- R5: Outside the CRC phase, `tx_word_o` equals `tx_data_i`. Inside it, `tx_word_o` carries the TX accumulator, zero-extended.
  - This does not apply in the two-frame case; there `tx_word_o` carries bits 15:8 of the accumulator and then bits 7:0, each in `tx_word_o[7:0]`.
- R6: Both accumulators hold their values throughout the CRC phase, including across the CRC frames.
- R7: The CRC phase ends after one CRC frame, or after two in the two-frame case (`crc16_i`=1, `frame16_i`=0). At that point the received value is compared with the RX accumulator, and a mismatch sets `crc_err_o`.
  - A 16-bit frame is compared whole. An 8-bit frame is compared as its low byte, zero-extended.
- R8: `crc_err_o` stays 1 until `err_clr_i` is pulsed, and later frames do not clear it. If a mismatch and a clear happen in the same cycle, the mismatch wins.
- R9: While `crc_en_i` is 0, both accumulators hold, completed frames are ignored, `crc_next_set_i` is ignored, and no CRC phase is active.
- R10: In the two-frame case, the received bytes are assembled with the first as the high byte and the second as the low byte. After the first CRC frame, the phase stays active and no comparison is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| crc_en_i | input | 1 | CRC enable; a rising edge clears the accumulators |
| crc_next_set_i | input | 1 | One-cycle request to append the CRC after the current frame |
| crc16_i | input | 1 | 1: 16-bit CRC, 0: 8-bit CRC |
| frame16_i | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| poly_i | input | 16 | Generator polynomial (odd) |
| err_clr_i | input | 1 | Clears the CRC error flag |
| frame_done_i | input | 1 | Strobe: the current frame has finished shifting |
| tx_data_i | input | 16 | Word from the transmit buffer for the current frame |
| rx_data_i | input | 16 | Word received in the current frame |
| tx_word_o | output | 16 | Word for the shifter to transmit |
| crc_phase_o | output | 1 | CRC frames are being shifted |
| crc_next_o | output | 1 | CRC append request pending |
| crc_err_o | output | 1 | Sticky CRC mismatch flag |
| tx_crc_o | output | 16 | TX accumulator |
| rx_crc_o | output | 16 | RX accumulator |

## Verification
The bench goes after the two-frame split.
- If the byte order were swapped, the transmit word in the first CRC frame would carry the low byte.
- If the phase ended after one frame, a correct pair of bytes would be compared early against half a value.

Freezing is checked by reading both accumulators after every CRC frame. An unfrozen design would fold its own checksum back in and then flag a false error on a correct transfer. Sticky error behaviour is probed with a deliberately corrupted checksum followed by ordinary frames. Disable handling is probed with frames and append requests sent while CRC is off, followed by a re-enable that must zero a non-zero checksum.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;
  localparam int MAX_W  = 16;
  localparam int HALF_W = MAX_W / 2;
  typedef logic [MAX_W-1:0]  word_t;
  typedef logic [HALF_W-1:0] half_t;

  // one whole frame, MSB first; 8-bit crc kept in the low half
  function automatic word_t crc_step(word_t crc, word_t data, word_t poly,
                                     logic crc16, logic frame16);
    word_t c;
    logic  top;
    c = crc;
    for (int i = MAX_W - 1; i >= 0; i--) begin
      if (frame16 || i < HALF_W) begin
        top = crc16 ? c[MAX_W-1] : c[HALF_W-1];
        c   = c << 1;
        if (top ^ data[i]) c = c ^ poly;
        if (!crc16) c[MAX_W-1:HALF_W] = '0;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/spi_crc_acc.sv
module spi_crc_acc
  import spi_crc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  upd_i,
  input  word_t data_i,
  input  word_t poly_i,
  input  logic  crc16_i,
  input  logic  frame16_i,
  output word_t crc_o
);
  word_t crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (upd_i) crc_q <= crc_step(crc_q, data_i, poly_i, crc16_i, frame16_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/spi_crc_seq.sv
module spi_crc_seq
  import spi_crc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  crc_en_i,
  input  logic  next_set_i,
  input  logic  frame_done_i,
  input  logic  crc16_i,
  input  logic  frame16_i,
  input  logic  err_clr_i,
  input  word_t tx_data_i,
  input  word_t rx_data_i,
  input  word_t tx_crc_i,
  input  word_t rx_crc_i,
  output logic  clr_o,
  output logic  upd_o,
  output word_t tx_word_o,
  output logic  phase_o,
  output logic  next_o,
  output logic  err_o
);
  logic  en_q, phase_q, idx_q, next_q, err_q;
  half_t hi_q;
  logic  two_frames, last_crc, mismatch;
  word_t rx_val;

  assign two_frames = crc16_i & ~frame16_i;
  assign clr_o      = crc_en_i & ~en_q;
  assign upd_o      = crc_en_i & frame_done_i & ~phase_q;
  assign last_crc   = crc_en_i & phase_q & frame_done_i & (~two_frames | idx_q);

  always_comb begin
    if (two_frames)     rx_val = {hi_q, rx_data_i[HALF_W-1:0]};
    else if (frame16_i) rx_val = rx_data_i;
    else                rx_val = {{HALF_W{1'b0}}, rx_data_i[HALF_W-1:0]};
  end
  assign mismatch = last_crc & (rx_val != rx_crc_i);

  always_comb begin
    if (!phase_q)        tx_word_o = tx_data_i;
    else if (!two_frames) tx_word_o = tx_crc_i;
    else if (!idx_q)     tx_word_o = {{HALF_W{1'b0}}, tx_crc_i[MAX_W-1:HALF_W]};
    else                 tx_word_o = {{HALF_W{1'b0}}, tx_crc_i[HALF_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      phase_q <= 1'b0;
      idx_q   <= 1'b0;
      next_q  <= 1'b0;
      hi_q    <= '0;
    end else begin
      en_q <= crc_en_i;
      if (!crc_en_i) begin
        phase_q <= 1'b0;
        idx_q   <= 1'b0;
        next_q  <= 1'b0;
      end else begin
        if (frame_done_i && next_q && !phase_q) begin
          phase_q <= 1'b1;
          idx_q   <= 1'b0;
          next_q  <= 1'b0;
        end else if (frame_done_i && phase_q) begin
          if (last_crc) begin
            phase_q <= 1'b0;
            idx_q   <= 1'b0;
          end else begin
            idx_q <= 1'b1;
            hi_q  <= rx_data_i[HALF_W-1:0];
          end
        end
        if (next_set_i) next_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (mismatch)  err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign phase_o = phase_q;
  assign next_o  = next_q;
  assign err_o   = err_q;
endmodule

// File: rtl/spi_crc_unit.sv
module spi_crc_unit
  import spi_crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              crc_en_i,
  input  logic              crc_next_set_i,
  input  logic              crc16_i,
  input  logic              frame16_i,
  input  logic [MAX_W-1:0]  poly_i,
  input  logic              err_clr_i,
  input  logic              frame_done_i,
  input  logic [MAX_W-1:0]  tx_data_i,
  input  logic [MAX_W-1:0]  rx_data_i,
  output logic [MAX_W-1:0]  tx_word_o,
  output logic              crc_phase_o,
  output logic              crc_next_o,
  output logic              crc_err_o,
  output logic [MAX_W-1:0]  tx_crc_o,
  output logic [MAX_W-1:0]  rx_crc_o
);
  localparam int N_ACC = 2;

  logic  clr, upd;
  word_t acc_data [N_ACC];
  word_t acc_crc  [N_ACC];

  assign acc_data[0] = tx_data_i;
  assign acc_data[1] = rx_data_i;

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    spi_crc_acc u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .upd_i     (upd),
      .data_i    (acc_data[g]),
      .poly_i    (poly_i),
      .crc16_i   (crc16_i),
      .frame16_i (frame16_i),
      .crc_o     (acc_crc[g])
    );
  end

  assign tx_crc_o = acc_crc[0];
  assign rx_crc_o = acc_crc[1];

  spi_crc_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .crc_en_i     (crc_en_i),
    .next_set_i   (crc_next_set_i),
    .frame_done_i (frame_done_i),
    .crc16_i      (crc16_i),
    .frame16_i    (frame16_i),
    .err_clr_i    (err_clr_i),
    .tx_data_i    (tx_data_i),
    .rx_data_i    (rx_data_i),
    .tx_crc_i     (acc_crc[0]),
    .rx_crc_i     (acc_crc[1]),
    .clr_o        (clr),
    .upd_o        (upd),
    .tx_word_o    (tx_word_o),
    .phase_o      (crc_phase_o),
    .next_o       (crc_next_o),
    .err_o        (crc_err_o)
  );
endmodule

// File: rtl/spi_crc_unit_chk.sv
module spi_crc_unit_chk
  import spi_crc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             crc_en_i,
  input logic             err_clr_i,
  input logic [MAX_W-1:0] tx_data_i,
  input logic [MAX_W-1:0] tx_word_o,
  input logic             crc_phase_o,
  input logic             crc_next_o,
  input logic             crc_err_o,
  input logic [MAX_W-1:0] tx_crc_o,
  input logic [MAX_W-1:0] rx_crc_o
);
  p_clear_on_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_en_i) |=> (tx_crc_o == '0) && (rx_crc_o == '0));

  p_next_dropped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_phase_o) |-> !crc_next_o);

  p_passthrough_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_phase_o |-> tx_word_o == tx_data_i);

  p_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_phase_o && crc_en_i |=> $stable(tx_crc_o) && $stable(rx_crc_o));

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_err_o && !err_clr_i |=> crc_err_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !crc_en_i |=> $stable(tx_crc_o) && $stable(rx_crc_o) && !crc_phase_o && !crc_next_o);
endmodule

bind spi_crc_unit spi_crc_unit_chk u_chk (.*);

// File: tb/spi_crc_unit_bench.sv
`timescale 1ns/1ps
module spi_crc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crc_en = 1'b0, next_set = 1'b0, crc16 = 1'b0, frame16 = 1'b0;
  logic [15:0] poly = 16'h0007;
  logic        err_clr = 1'b0, frame_done = 1'b0;
  logic [15:0] tx_data = '0, rx_data = '0;
  logic [15:0] tx_word, tx_crc, rx_crc;
  logic        phase, nxt, err;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_tx, m_rx;

  always #5 clk = ~clk;

  spi_crc_unit u_spi_crc_unit (
    .clk_i(clk), .rst_ni(rst_n), .crc_en_i(crc_en), .crc_next_set_i(next_set),
    .crc16_i(crc16), .frame16_i(frame16), .poly_i(poly), .err_clr_i(err_clr),
    .frame_done_i(frame_done), .tx_data_i(tx_data), .rx_data_i(rx_data),
    .tx_word_o(tx_word), .crc_phase_o(phase), .crc_next_o(nxt), .crc_err_o(err),
    .tx_crc_o(tx_crc), .rx_crc_o(rx_crc));

  // reference: bit-serial CRC of width w over a frame of fw bits
  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [15:0] d,
                                          logic [15:0] p, int w, int fw);
    logic [15:0] mask = (w == 16) ? 16'hFFFF : 16'h00FF;
    for (int k = fw - 1; k >= 0; k--) begin
      logic fb = c[w-1] ^ d[k];
      c = (c << 1) & mask;
      if (fb) c = (c ^ p) & mask;
    end
    return c;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic frame(logic [15:0] t, logic [15:0] r);
    tx_data = t; rx_data = r; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic data_frame(logic [15:0] t, logic [15:0] r);
    int w  = crc16 ? 16 : 8;
    int fw = frame16 ? 16 : 8;
    frame(t, r);
    m_tx = ref_crc(m_tx, t, poly, w, fw);
    m_rx = ref_crc(m_rx, r, poly, w, fw);
  endtask

  task automatic restart_crc;
    crc_en = 1'b0; @(negedge clk);
    crc_en = 1'b1; @(negedge clk);
    m_tx = '0; m_rx = '0;
    chk("R2 tx clear", tx_crc, 16'h0);
    chk("R2 rx clear", rx_crc, 16'h0);
  endtask

  task automatic request_next;
    next_set = 1'b1; @(negedge clk); next_set = 1'b0;
    chk("R4 next set", {15'b0, nxt}, 16'h1);
  endtask

  task automatic t_reset;
    chk("R1 tx acc", tx_crc, 16'h0);
    chk("R1 rx acc", rx_crc, 16'h0);
    chk("R1 flags", {13'b0, phase, nxt, err}, 16'h0);
  endtask

  task automatic t_crc8_frame8;
    poly = 16'h0007; crc16 = 1'b0; frame16 = 1'b0;
    restart_crc();
    data_frame(16'h00A5, 16'h003C);
    chk("R3 tx crc8", tx_crc, m_tx);
    chk("R3 rx crc8", rx_crc, m_rx);
    data_frame(16'hFF12, 16'hAAF0);   // upper bytes ignored in 8-bit frames
    chk("R3 tx crc8 b", tx_crc, m_tx);
    request_next();
    data_frame(16'h005A, 16'h0077);
    chk("R4 phase on", {15'b0, phase}, 16'h1);
    chk("R4 next off", {15'b0, nxt}, 16'h0);
    chk("R3 last fold", tx_crc, m_tx);
    tx_data = 16'h00EE;
    #1;
    chk("R5 crc on tx", tx_word, m_tx);
    frame(16'h00EE, m_rx);
    chk("R7 phase end", {15'b0, phase}, 16'h0);
    chk("R7 match no err", {15'b0, err}, 16'h0);
    chk("R6 tx frozen", tx_crc, m_tx);
    chk("R6 rx frozen", rx_crc, m_rx);
    chk("R5 passthrough", tx_word, 16'h00EE);
  endtask

  task automatic t_crc16_frame8(bit corrupt);
    poly = 16'h1021; crc16 = 1'b1; frame16 = 1'b0;
    restart_crc();
    data_frame(16'h0031, 16'h0032);
    data_frame(16'h00C7, 16'h0019);
    chk("R3 tx crc16/8", tx_crc, m_tx);
    chk("R3 rx crc16/8", rx_crc, m_rx);
    request_next();
    data_frame(16'h0004, 16'h00D2);
    chk("R10 high byte first", tx_word, {8'h00, m_tx[15:8]});
    frame(16'h0000, {8'h00, m_rx[15:8] ^ (corrupt ? 8'h01 : 8'h00)});
    chk("R10 phase holds", {15'b0, phase}, 16'h1);
    chk("R10 no early compare", {15'b0, err}, 16'h0);
    chk("R10 low byte second", tx_word, {8'h00, m_tx[7:0]});
    chk("R6 tx frozen 2f", tx_crc, m_tx);
    frame(16'h0000, {8'h00, m_rx[7:0]});
    chk("R7 phase end 2f", {15'b0, phase}, 16'h0);
    chk("R7 compare 2f", {15'b0, err}, {15'b0, corrupt});
    chk("R6 rx frozen 2f", rx_crc, m_rx);
  endtask

  task automatic t_sticky;
    data_frame(16'h0011, 16'h0022);
    data_frame(16'h0033, 16'h0044);
    chk("R8 sticky after frames", {15'b0, err}, 16'h1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk("R8 cleared", {15'b0, err}, 16'h0);
  endtask

  task automatic t_crc16_frame16;
    poly = 16'h8005; crc16 = 1'b1; frame16 = 1'b1;
    restart_crc();
    data_frame(16'hBEEF, 16'h1234);
    data_frame(16'h0F0F, 16'hCAFE);
    chk("R3 tx crc16/16", tx_crc, m_tx);
    chk("R3 rx crc16/16", rx_crc, m_rx);
    request_next();
    data_frame(16'h8001, 16'h7FFE);
    chk("R5 full crc word", tx_word, m_tx);
    frame(16'h0000, m_rx ^ 16'h8000);
    chk("R7 single frame end", {15'b0, phase}, 16'h0);
    chk("R7 mismatch 16", {15'b0, err}, 16'h1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_disabled;
    logic [15:0] h_tx = tx_crc, h_rx = rx_crc;
    chk("R9 nonzero before", {15'b0, h_tx != 16'h0}, 16'h1);
    crc_en = 1'b0; @(negedge clk);
    frame(16'h5555, 16'hAAAA);
    chk("R9 tx hold", tx_crc, h_tx);
    chk("R9 rx hold", rx_crc, h_rx);
    next_set = 1'b1; @(negedge clk); next_set = 1'b0;
    chk("R9 next ignored", {15'b0, nxt}, 16'h0);
    frame(16'h1111, 16'h2222);
    chk("R9 no phase", {15'b0, phase}, 16'h0);
    crc_en = 1'b1; @(negedge clk);
    chk("R2 reenable tx", tx_crc, 16'h0);
    chk("R2 reenable rx", rx_crc, 16'h0);
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_tx = '0; m_rx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_crc8_frame8();
    t_crc16_frame8(1'b1);
    t_sticky();
    t_crc16_frame8(1'b0);
    t_crc16_frame16();
    t_disabled();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule